// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is the output stage of one programmable-logic cell. A small set of product-term inputs comes in, together with an optional partial sum handed over by a neighbouring cell. Selected terms are ORed together and passed through a polarity XOR to form the cell's data bit. That bit then goes to a storage element that acts as a D flip-flop or a T flip-flop, or it goes straight to the output when the storage element is bypassed.

Dedicated term positions can also serve as controls: a clock, a clock enable, an asynchronous set, an asynchronous reset and an output enable. The clock comes from one of several global clocks or from the product-term clock, in true or inverted polarity. A global set/reset forces a per-cell value. A power-on reset loads a preload value.

All configuration is supplied on static input pins. Configuration is meant to change only while the register is held by an asynchronous control.

Top module: `mc_stage`

## Requirements
- R1: The data bit is the OR of every `pt[i]` whose `cfg_term_mask[i]` is 1, ORed with `casc_in` when `cfg_term_mask[5]` is 1, and then XORed with `cfg_inv`.
- R2: When `cfg_mode` is 2'b00 the register is bypassed and `mc_out` follows the data bit combinationally.
- R3: When `cfg_mode` is 2'b01 (D) or 2'b11 (treated as D), an enabled rising edge of the effective clock stores the data bit, and `mc_out` shows the stored value.
- R4: When `cfg_mode` is 2'b10 (T), an enabled edge inverts the stored value if the data bit is 1 and keeps it if the data bit is 0.
- R5: `cfg_clk_sel` values 0 to 2 pick `gclk[cfg_clk_sel]`, and value 3 picks `pt[1]`. With `cfg_clk_inv` = 1 the register updates on the falling edge of the picked clock instead.
- R6: With `cfg_ce_en` = 1, a clock edge while `pt[2]` is 0 leaves the stored value unchanged. With `cfg_ce_en` = 0 every edge updates.
- R7: With `cfg_rst_en` = 1, `pt[4]` high clears the register asynchronously. With `cfg_set_en` = 1, `pt[3]` high sets it. When both are active, the clear wins.
- R8: `gsr` high forces the register to `cfg_gsr_val` asynchronously and overrides the term set and clear.
- R9: `por_n` low loads `cfg_preload` and overrides every other control.
- R10: `oe_out` equals `pt[0]` when `cfg_oe_en` is 1 and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 3 | Global clocks |
| por_n | input | 1 | Power-on reset, active low, loads preload |
| gsr | input | 1 | Global set/reset, active high |
| pt | input | 5 | Direct product terms |
| casc_in | input | 1 | Partial sum from a neighbouring cell |
| cfg_mode | input | 2 | 00 bypass, 01 D, 10 T, 11 D |
| cfg_term_mask | input | 6 | Bits 4..0 select terms for the OR, bit 5 selects casc_in |
| cfg_inv | input | 1 | Output polarity XOR |
| cfg_clk_sel | input | 2 | Clock source: 0..2 global, 3 product term |
| cfg_clk_inv | input | 1 | Use the falling edge of the chosen clock |
| cfg_ce_en | input | 1 | Use pt[2] as clock enable |
| cfg_set_en | input | 1 | Use pt[3] as asynchronous set |
| cfg_rst_en | input | 1 | Use pt[4] as asynchronous clear |
| cfg_oe_en | input | 1 | Use pt[0] as output enable |
| cfg_gsr_val | input | 1 | Value forced by gsr |
| cfg_preload | input | 1 | Value loaded at power-on |
| mc_out | output | 1 | Cell output |
| oe_out | output | 1 | Output enable |

## Verification
The hardest case to reach is an edge from the product-term clock or from an inverted global clock that arrives while data, enable and asynchronous controls are all changing. The stimulus handles this by dividing every 4 ns slot into fixed phases: global-clock edges, then the product-term clock toggle, then data changes, then the comparison. This means exactly one kind of event happens at each instant. Clock sources are switched only while `gsr` has been held for a full slot. As a result, the glitch that a source change creates falls inside an asynchronous hold, which both the design and the model ignore.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [1:0] {
      MC_BYPASS = 2'b00,
      MC_DREG   = 2'b01,
      MC_TREG   = 2'b10,
      MC_DALT   = 2'b11
   } mc_mode_e;
endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
   parameter int N_TERMS     = 5,
   parameter bit HAS_CASCADE = 1'b1
) (
   input  logic [N_TERMS-1:0] terms,
   input  logic               casc,
   input  logic [N_TERMS:0]   mask,
   input  logic               inv,
   output logic               d
);
   logic casc_part;
   logic term_part;

   generate
      if (HAS_CASCADE) begin : g_casc
         assign casc_part = casc & mask[N_TERMS];
      end else begin : g_nocasc
         assign casc_part = 1'b0;
      end
   endgenerate

   assign term_part = |(terms & mask[N_TERMS-1:0]);
   assign d         = (term_part | casc_part) ^ inv;
endmodule

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
   parameter int N_GCLK = 3,
   parameter int SEL_W  = 2
) (
   input  logic [N_GCLK-1:0] gclk,
   input  logic              ptclk,
   input  logic [SEL_W-1:0]  sel,
   input  logic              inv,
   output logic              clk_eff
);
   logic picked;

   always_comb begin
      picked = ptclk;
      for (int i = 0; i < N_GCLK; i++) begin
         if (sel == SEL_W'(i)) picked = gclk[i];
      end
   end

   assign clk_eff = picked ^ inv;
endmodule

// File: rtl/mc_async.sv
module mc_async (
   input  logic por_n,
   input  logic gsr,
   input  logic gsr_val,
   input  logic preload,
   input  logic pt_set,
   input  logic pt_rst,
   output logic aset,
   output logic arst
);
   always_comb begin
      aset = 1'b0;
      arst = 1'b0;
      if (!por_n) begin
         aset = preload;
         arst = ~preload;
      end else if (gsr) begin
         aset = gsr_val;
         arst = ~gsr_val;
      end else if (pt_rst) begin
         arst = 1'b1;
      end else if (pt_set) begin
         aset = 1'b1;
      end
   end
endmodule

// File: rtl/mc_stage.sv
module mc_stage
   import mc_pkg::*;
#(
   parameter int N_TERMS     = 5,
   parameter int N_GCLK      = 3,
   parameter int OE_IDX      = 0,
   parameter int PTCLK_IDX   = 1,
   parameter int CE_IDX      = 2,
   parameter int SET_IDX     = 3,
   parameter int RST_IDX     = 4,
   parameter bit HAS_CASCADE = 1'b1,
   localparam int SEL_W      = $clog2(N_GCLK + 1)
) (
   input  logic [N_GCLK-1:0]  gclk,
   input  logic               por_n,
   input  logic               gsr,
   input  logic [N_TERMS-1:0] pt,
   input  logic               casc_in,
   input  logic [1:0]         cfg_mode,
   input  logic [N_TERMS:0]   cfg_term_mask,
   input  logic               cfg_inv,
   input  logic [SEL_W-1:0]   cfg_clk_sel,
   input  logic               cfg_clk_inv,
   input  logic               cfg_ce_en,
   input  logic               cfg_set_en,
   input  logic               cfg_rst_en,
   input  logic               cfg_oe_en,
   input  logic               cfg_gsr_val,
   input  logic               cfg_preload,
   output logic               mc_out,
   output logic               oe_out
);
   generate
      if (N_TERMS < 5 || N_GCLK < 1) begin : g_bad_size
         $error("mc_stage: needs at least five terms and one global clock");
      end
      if (OE_IDX >= N_TERMS || PTCLK_IDX >= N_TERMS || CE_IDX >= N_TERMS ||
          SET_IDX >= N_TERMS || RST_IDX >= N_TERMS) begin : g_bad_idx
         $error("mc_stage: control term index outside the term vector");
      end
   endgenerate

   mc_mode_e mode;
   logic     d_sum;
   logic     clk_eff;
   logic     aset;
   logic     arst;
   logic     ce;
   logic     q;
   logic     q_next;

   assign mode = mc_mode_e'(cfg_mode);

   mc_sum #(.N_TERMS(N_TERMS), .HAS_CASCADE(HAS_CASCADE)) u_sum (
      .terms (pt),
      .casc  (casc_in),
      .mask  (cfg_term_mask),
      .inv   (cfg_inv),
      .d     (d_sum)
   );

   mc_clk_sel #(.N_GCLK(N_GCLK), .SEL_W(SEL_W)) u_clk (
      .gclk    (gclk),
      .ptclk   (pt[PTCLK_IDX]),
      .sel     (cfg_clk_sel),
      .inv     (cfg_clk_inv),
      .clk_eff (clk_eff)
   );

   mc_async u_async (
      .por_n   (por_n),
      .gsr     (gsr),
      .gsr_val (cfg_gsr_val),
      .preload (cfg_preload),
      .pt_set  (cfg_set_en & pt[SET_IDX]),
      .pt_rst  (cfg_rst_en & pt[RST_IDX]),
      .aset    (aset),
      .arst    (arst)
   );

   assign ce = cfg_ce_en ? pt[CE_IDX] : 1'b1;

   always_comb begin
      case (mode)
         MC_TREG: q_next = q ^ d_sum;
         default: q_next = d_sum;
      endcase
   end

   always_ff @(posedge clk_eff or posedge arst or posedge aset) begin
      if (arst)      q <= 1'b0;
      else if (aset) q <= 1'b1;
      else if (ce)   q <= q_next;
   end

   assign mc_out = (mode == MC_BYPASS) ? d_sum : q;
   assign oe_out = cfg_oe_en ? pt[OE_IDX] : 1'b1;
endmodule

// File: rtl/mc_stage_chk.sv
module mc_stage_chk #(
   parameter int N_TERMS = 5,
   parameter int N_GCLK  = 3,
   parameter int OE_IDX  = 0,
   parameter int SET_IDX = 3,
   parameter int RST_IDX = 4
) (
   input logic [N_GCLK-1:0]  gclk,
   input logic               por_n,
   input logic               gsr,
   input logic [N_TERMS-1:0] pt,
   input logic               casc_in,
   input logic [1:0]         cfg_mode,
   input logic               cfg_inv,
   input logic               cfg_set_en,
   input logic               cfg_rst_en,
   input logic               cfg_oe_en,
   input logic               cfg_gsr_val,
   input logic               cfg_preload,
   input logic               mc_out,
   input logic               oe_out
);
   // R2: bypass with nothing active yields the polarity bit alone
   a_r2_bypass_idle: assert property (@(posedge gclk[0]) disable iff (!por_n)
      (cfg_mode == 2'b00 && pt == '0 && !casc_in) |-> (mc_out == cfg_inv));

   // R7: clear beats set
   a_r7_clear_wins: assert property (@(posedge gclk[0]) disable iff (!por_n)
      (cfg_mode != 2'b00 && !gsr && cfg_rst_en && pt[RST_IDX]) |-> (mc_out == 1'b0));

   // R8: global set/reset overrides term controls
   a_r8_gsr_forces: assert property (@(posedge gclk[0]) disable iff (!por_n)
      (cfg_mode != 2'b00 && gsr) |-> (mc_out == cfg_gsr_val));

   // R9: power-on preload dominates
   a_r9_preload: assert property (@(posedge gclk[0])
      (cfg_mode != 2'b00 && !por_n) |-> (mc_out == cfg_preload));

   // R10: output enable defaults high
   a_r10_oe_default: assert property (@(posedge gclk[0]) disable iff (!por_n)
      !cfg_oe_en |-> oe_out);

   // R7: an active set with no clear and no gsr drives the output high
   a_r7_set_alone: assert property (@(posedge gclk[0]) disable iff (!por_n)
      (cfg_mode != 2'b00 && !gsr && cfg_set_en && pt[SET_IDX] &&
       !(cfg_rst_en && pt[RST_IDX])) |-> mc_out);
endmodule

bind mc_stage mc_stage_chk #(
   .N_TERMS (N_TERMS),
   .N_GCLK  (N_GCLK),
   .OE_IDX  (OE_IDX),
   .SET_IDX (SET_IDX),
   .RST_IDX (RST_IDX)
) u_chk (
   .gclk        (gclk),
   .por_n       (por_n),
   .gsr         (gsr),
   .pt          (pt),
   .casc_in     (casc_in),
   .cfg_mode    (cfg_mode),
   .cfg_inv     (cfg_inv),
   .cfg_set_en  (cfg_set_en),
   .cfg_rst_en  (cfg_rst_en),
   .cfg_oe_en   (cfg_oe_en),
   .cfg_gsr_val (cfg_gsr_val),
   .cfg_preload (cfg_preload),
   .mc_out      (mc_out),
   .oe_out      (oe_out)
);

// File: tb/sim_mc_stage.sv
`timescale 1ns/1ps
module sim_mc_stage;
   logic [2:0] gclk = '0;
   logic       por_n = 1'b1, gsr = 1'b0, casc_in = 1'b0;
   logic [4:0] pt = '0;
   logic [1:0] cfg_mode = 2'b01, cfg_clk_sel = 2'd0;
   logic [5:0] cfg_term_mask = '0;
   logic cfg_inv = 0, cfg_clk_inv = 0, cfg_ce_en = 0, cfg_set_en = 0, cfg_rst_en = 0;
   logic cfg_oe_en = 0, cfg_gsr_val = 0, cfg_preload = 0;
   logic mc_out, oe_out;

   mc_stage u0 (.gclk, .por_n, .gsr, .pt, .casc_in, .cfg_mode, .cfg_term_mask, .cfg_inv,
                .cfg_clk_sel, .cfg_clk_inv, .cfg_ce_en, .cfg_set_en, .cfg_rst_en,
                .cfg_oe_en, .cfg_gsr_val, .cfg_preload, .mc_out, .oe_out);

   // 125 MHz base clock; slower globals derived on the same 4 ns grid
   int tick = 0;
   always #4 begin
      tick++;
      gclk[0] = ~gclk[0];
      if (tick % 2 == 0) gclk[1] = ~gclk[1];
      if (tick % 3 == 0) gclk[2] = ~gclk[2];
   end

   int n_checks = 0, n_fail = 0;
   bit done = 0;
   string tag = "R9";

   // next-slot stimulus
   logic [4:0] nx_pt = '0;
   logic nx_casc = 0, nx_gsr = 0, nx_por_n = 1;

   // reference model state
   bit ref_q = 0, prev_clk = 0, prev_async = 1, prev_d = 0, prev_ce = 1;

   function automatic bit data_bit();
      bit s = 0;
      for (int i = 0; i < 5; i++) if (cfg_term_mask[i] && pt[i]) s = 1;
      if (cfg_term_mask[5] && casc_in) s = 1;
      return s ^ cfg_inv;
   endfunction

   function automatic bit eff_clk();
      bit c = (cfg_clk_sel == 2'd3) ? pt[1] : gclk[cfg_clk_sel];
      return c ^ cfg_clk_inv;
   endfunction

   task automatic check(string req, bit act, bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
      end
   endtask

   task automatic step();
      bit async_now, aval, c;
      #1;
      if (cfg_clk_sel == 2'd3) pt[1] = ~pt[1];
      #1;
      pt      = (cfg_clk_sel == 2'd3) ? {nx_pt[4:2], pt[1], nx_pt[0]} : nx_pt;
      casc_in = nx_casc;
      gsr     = nx_gsr;
      por_n   = nx_por_n;
      #1;
      c = eff_clk();
      if (!prev_clk && c && !prev_async && prev_ce) begin
         if (cfg_mode == 2'b10) ref_q = ref_q ^ prev_d;
         else ref_q = prev_d;
      end
      async_now = 1; aval = 0;
      if (!por_n) aval = cfg_preload;
      else if (gsr) aval = cfg_gsr_val;
      else if (cfg_rst_en && pt[4]) aval = 0;
      else if (cfg_set_en && pt[3]) aval = 1;
      else async_now = 0;
      if (async_now) ref_q = aval;
      check(tag, mc_out, (cfg_mode == 2'b00) ? data_bit() : ref_q);
      check("R10", oe_out, cfg_oe_en ? pt[0] : 1'b1);
      prev_clk = c; prev_async = async_now; prev_d = data_bit();
      prev_ce = cfg_ce_en ? pt[2] : 1'b1;
      #1;
   endtask

   task automatic hold_gsr_begin();
      nx_gsr = 1; step();
   endtask

   task automatic rand_pt(bit keep_ctl);
      nx_pt = 5'($urandom);
      nx_casc = 1'($urandom);
      if (keep_ctl) nx_pt[4:3] = 2'b00;
   endtask

   initial begin
      // R9: power-on preload, dominant over gsr
      cfg_preload = 1; nx_por_n = 0; step();
      tag = "R9"; step(); step();
      nx_gsr = 1; cfg_gsr_val = 0; step(); step();
      cfg_preload = 0; step();
      nx_por_n = 1; step();
      // R8: gsr value with term set/clear also active
      tag = "R8"; cfg_gsr_val = 1; cfg_set_en = 1; cfg_rst_en = 1; nx_pt = 5'b10000; step(); step();
      nx_pt = 5'b11000; step();
      cfg_set_en = 0; cfg_rst_en = 0; nx_pt = 0; step();
      // R1, R2: bypass with random masks and polarity
      tag = "R1 R2"; cfg_mode = 2'b00; nx_gsr = 0;
      for (int k = 0; k < 40; k++) begin
         cfg_term_mask = 6'($urandom); cfg_inv = 1'($urandom); cfg_oe_en = 1'($urandom);
         rand_pt(0); step();
      end
      // R3 R4 R5 R6: every clock source, polarity, register type, enable
      for (int m = 0; m < 3; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int inv = 0; inv < 2; inv++) begin
               hold_gsr_begin();
               cfg_mode = (m == 0) ? 2'b01 : (m == 1) ? 2'b10 : 2'b11;
               cfg_clk_sel = 2'(s); cfg_clk_inv = 1'(inv);
               cfg_ce_en = 1'($urandom); cfg_gsr_val = 1'($urandom);
               cfg_term_mask = 6'($urandom);
               if (s == 3) cfg_term_mask[1] = 0;
               tag = (m == 1) ? "R4 R5 R6" : "R3 R5 R6";
               step();
               nx_gsr = 0;
               for (int k = 0; k < 24; k++) begin rand_pt(1); step(); end
            end
         end
      end
      // R7: term set and clear, with random overlap
      tag = "R7";
      hold_gsr_begin();
      cfg_mode = 2'b01; cfg_clk_sel = 0; cfg_clk_inv = 0; cfg_ce_en = 0;
      cfg_set_en = 1; cfg_rst_en = 1; cfg_term_mask = 6'b000001; step();
      nx_gsr = 0;
      for (int k = 0; k < 40; k++) begin rand_pt(0); step(); end
      nx_pt = 5'b11000; step(); step();
      nx_pt = 5'b01000; step(); step();
      // R8: random gsr over term controls
      tag = "R8";
      for (int k = 0; k < 30; k++) begin
         rand_pt(0); nx_gsr = 1'($urandom);
         step();
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule